// File: doc/BRIEF.md
# Serial Divider-Ratio Loader for a Frequency Synthesizer

This block receives control words for a synthesizer over a three-wire serial link: a serial clock, a serial data line and an enable that is active low. While the enable is held low, each rising edge of the serial clock pushes one data bit into a 14-bit shift register. Edges that arrive while the enable is high are dropped. The link has no framing check, so a burst can carry any number of bits, including none. The register always holds the 14 bits received most recently.

When the enable returns high, the two bits received last act as a destination code. The 12 bits before them are the payload. The payload is copied into the 8-bit reference-ratio latch or into the 12-bit main-ratio latch, and the block raises a one-cycle strobe. If the serial clock is still low at the moment the enable rises, that release counts as one more shift edge, and the current data level enters the register before the decode. All three serial inputs pass through two-flop synchronizers into the system clock domain.

Top module: `synth_ser_prog`

## Requirements
- R1: While the enable input is high, serial clock edges and data levels leave the shift register unchanged. A burst with no clock pulses therefore re-applies the word still held in the register.
- R2: Each synchronized rising edge of the serial clock, seen while the enable is low, shifts the register left by one and puts the data level in bit 0. The first bit sent ends up in bit 13 and the last bit sent in bit 0. Bits 13..2 form the payload, with the first bit sent as its MSB. Bits 1..0 form the destination code, with the second-to-last bit sent in bit 1.
- R3: A burst may hold any number of clock pulses. Only the last 14 bits decide the result.
- R4: The latches change only when the enable rises, and then from the register contents.
- R5: If the enable rises while the synchronized serial clock is low, the register shifts once more and takes in the data level present at that moment. It does so before the decode.
- R6: Destination code 01 loads payload bits 7..0 into the reference ratio. Payload bits 11..8 have no effect.
- R7: Destination code 11 loads all 12 payload bits into the main ratio.
- R8: Destination codes 00 and 10 change neither ratio and give no strobe.
- R9: The update strobe is high for exactly one clock cycle for each load under R6 or R7.
- R10: During and after reset, the reference ratio is 1, the main ratio is 128 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock; shifts on its rising edge |
| ser_dat_i | input | 1 | Serial data |
| ser_en_n_i | input | 1 | Burst enable, active low |
| ref_ratio_o | output | 8 | Latched reference divider ratio |
| main_ratio_o | output | 12 | Latched main divider ratio |
| update_o | output | 1 | One-cycle pulse when a ratio latch is loaded |

## Verification
Suppose a serial input changes just before rising clock edge k. The first synchronizer stage captures it at edge k and the second stage at edge k+1. The shift register and the registered commit flag react at edge k+2, and the ratio latches and the strobe change at edge k+3. The bench drives every serial level for four clock cycles before the next change. It reads the outputs on falling edges at least eight cycles after the enable rises, so every result is settled when it is sampled. The strobe is counted on each falling edge, so a pulse longer than one cycle, or a missing pulse, shows up as a wrong count.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IDLE_A = 2'b00,
        SEL_REF    = 2'b01,
        SEL_IDLE_B = 2'b10,
        SEL_MAIN   = 2'b11
    } sel_e;
endpackage

// File: rtl/synth_sync.sv
module synth_sync #(
    parameter int unsigned         W       = 3,
    parameter logic [W-1:0]        RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= async_i[i];
                s2_q <= s1_q;
            end
        end
        assign sync_o[i] = s2_q;
    end
endmodule

// File: rtl/synth_ser_front.sv
module synth_ser_front #(
    parameter int unsigned FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               en_n_s,
    output logic [FRAME_W-1:0] frame_o,
    output logic               commit_o
);
    typedef struct packed {
        logic               sclk_prev;
        logic               en_prev;
        logic [FRAME_W-1:0] sr;
        logic               commit;
    } front_t;

    front_t st_d, st_q;
    logic   sclk_rise;
    logic   release_ev;

    always_comb begin
        st_d           = st_q;
        sclk_rise      = sclk_s & ~st_q.sclk_prev;
        release_ev     = en_n_s & ~st_q.en_prev;
        st_d.sclk_prev = sclk_s;
        st_d.en_prev   = en_n_s;
        if (sclk_rise && !en_n_s) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], sdat_s};
        end
        if (release_ev && !sclk_s) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], sdat_s};
        end
        st_d.commit = release_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sclk_prev: 1'b1, en_prev: 1'b1, sr: '0, commit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o  = st_q.sr;
    assign commit_o = st_q.commit;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n_s && st_q.en_prev) |=> $stable(st_q.sr)); // R1
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !en_n_s) |=> (st_q.sr[0] == $past(sdat_s)
            && st_q.sr[FRAME_W-1:1] == $past(st_q.sr[FRAME_W-2:0]))); // R2
    AST_RELEASE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (release_ev && !sclk_s) |=> (st_q.sr[0] == $past(sdat_s))); // R5
endmodule

// File: rtl/synth_ratio_latch.sv
module synth_ratio_latch
    import synth_prog_pkg::*;
#(
    parameter int unsigned REF_W    = 8,
    parameter int unsigned MAIN_W   = 12,
    parameter int unsigned REF_RST  = 1,
    parameter int unsigned MAIN_RST = 128,
    localparam int unsigned FRAME_W = MAIN_W + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               commit_i,
    output logic [REF_W-1:0]   ref_o,
    output logic [MAIN_W-1:0]  main_o,
    output logic               strobe_o
);
    typedef struct packed {
        logic [REF_W-1:0]  ref_r;
        logic [MAIN_W-1:0] main_r;
        logic              strobe;
    } latch_t;

    latch_t st_d, st_q;
    sel_e   sel;
    logic   load_ref, load_main;

    always_comb begin
        st_d      = st_q;
        sel       = sel_e'(frame_i[SEL_W-1:0]);
        load_ref  = commit_i && (sel == SEL_REF);
        load_main = commit_i && (sel == SEL_MAIN);
        if (load_ref) begin
            st_d.ref_r = frame_i[SEL_W +: REF_W];
        end
        if (load_main) begin
            st_d.main_r = frame_i[SEL_W +: MAIN_W];
        end
        st_d.strobe = load_ref | load_main;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ref_r: REF_W'(REF_RST), main_r: MAIN_W'(MAIN_RST), strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o    = st_q.ref_r;
    assign main_o   = st_q.main_r;
    assign strobe_o = st_q.strobe;

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_ref, load_main})); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.strobe |-> ($stable(st_q.ref_r) && $stable(st_q.main_r))); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe); // R9
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> $past(commit_i)); // R4
endmodule

// File: rtl/synth_ser_prog.sv
module synth_ser_prog #(
    parameter int unsigned REF_W    = 8,
    parameter int unsigned MAIN_W   = 12,
    parameter int unsigned REF_RST  = 1,
    parameter int unsigned MAIN_RST = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_n_i,
    output logic [REF_W-1:0]  ref_ratio_o,
    output logic [MAIN_W-1:0] main_ratio_o,
    output logic              update_o
);
    localparam int unsigned FRAME_W = MAIN_W + synth_prog_pkg::SEL_W;

    logic [2:0]         sync_s;
    logic [FRAME_W-1:0] frame;
    logic               commit;

    synth_sync #(.W(3), .RST_VAL(3'b101)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en_n_i, ser_dat_i, ser_clk_i}),
        .sync_o  (sync_s)
    );

    synth_ser_front #(.FRAME_W(FRAME_W)) i_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sync_s[0]),
        .sdat_s   (sync_s[1]),
        .en_n_s   (sync_s[2]),
        .frame_o  (frame),
        .commit_o (commit)
    );

    synth_ratio_latch #(
        .REF_W(REF_W), .MAIN_W(MAIN_W), .REF_RST(REF_RST), .MAIN_RST(MAIN_RST)
    ) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_i  (frame),
        .commit_i (commit),
        .ref_o    (ref_ratio_o),
        .main_o   (main_ratio_o),
        .strobe_o (update_o)
    );
endmodule

// File: tb/test_synth_ser_prog.sv
module test_synth_ser_prog;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sdat = 1'b0, en_n = 1'b1;
    logic [7:0]  ref_r;
    logic [11:0] main_r;
    logic        upd;

    int checks = 0, errors = 0, stb_cnt = 0, stb_base;
    logic [13:0] shadow = '0;
    logic [7:0]  exp_ref = 8'd1;
    logic [11:0] exp_main = 12'd128;
    int          exp_stb = 0;

    always #2 clk = ~clk;

    synth_ser_prog i_synth_ser_prog (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_en_n_i(en_n), .ref_ratio_o(ref_r), .main_ratio_o(main_r), .update_o(upd)
    );

    always @(negedge clk) if (rst_n && upd) stb_cnt++;

    // frame, expected ref, expected main, strobe expected
    localparam logic [34:0] VEC [6] = '{
        {12'hA5C, 2'b11, 8'h01, 12'hA5C, 1'b1},
        {12'hF3C, 2'b01, 8'h3C, 12'hA5C, 1'b1},
        {12'h123, 2'b00, 8'h3C, 12'hA5C, 1'b0},
        {12'hFFF, 2'b10, 8'h3C, 12'hA5C, 1'b0},
        {12'h001, 2'b11, 8'h3C, 12'h001, 1'b1},
        {12'h0FF, 2'b01, 8'hFF, 12'h001, 1'b1}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; sdat = b; wait_cyc(4);
        sclk = 1'b1; wait_cyc(4);
        if (!en_n) shadow = {shadow[12:0], b};
    endtask

    task automatic model_commit();
        case (shadow[1:0])
            2'b01: begin exp_ref = shadow[9:2]; exp_stb++; end
            2'b11: begin exp_main = shadow[13:2]; exp_stb++; end
            default: ;
        endcase
    endtask

    task automatic release_high();
        en_n = 1'b1; wait_cyc(4);
        model_commit();
        wait_cyc(8);
    endtask

    task automatic release_low(input logic b);
        sclk = 1'b0; sdat = b; wait_cyc(4);
        en_n = 1'b1; shadow = {shadow[12:0], b}; wait_cyc(4);
        model_commit();
        sclk = 1'b1; wait_cyc(8);
    endtask

    task automatic send_frame(input logic [13:0] f);
        en_n = 1'b0; wait_cyc(4);
        for (int k = 13; k >= 0; k--) send_bit(f[k]);
        release_high();
    endtask

    task automatic check_model(input string req);
        check({req, " ref"},  32'(ref_r),  32'(exp_ref));
        check({req, " main"}, 32'(main_r), 32'(exp_main));
        check({req, " strobe count"}, 32'(stb_cnt), 32'(exp_stb));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        check("R10 reset ref", 32'(ref_r), 32'd1);
        check("R10 reset main", 32'(main_r), 32'd128);
        check("R10 reset strobe", 32'(upd), 32'd0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R10 after release ref", 32'(ref_r), 32'd1);

        // table walk: R2 R4 R6 R7 R8 R9
        for (int i = 0; i < 6; i++) begin
            stb_base = stb_cnt;
            send_frame(VEC[i][34:21]);
            check("R6/R7 table ref", 32'(ref_r), 32'(VEC[i][20:13]));
            check("R7 table main", 32'(main_r), 32'(VEC[i][12:1]));
            check("R8/R9 table strobe", 32'(stb_cnt - stb_base), 32'(VEC[i][0]));
        end
        exp_ref = 8'hFF; exp_main = 12'h001; exp_stb = stb_cnt;

        // R1: clocks with enable high are ignored; empty burst re-applies held word
        begin
            logic [13:0] junk = {12'h777, 2'b11};
            for (int k = 13; k >= 0; k--) send_bit(junk[k]);
        end
        check("R1 idle clocks main", 32'(main_r), 32'h001);
        en_n = 1'b0; wait_cyc(4);
        release_high();
        check_model("R1 R3 empty burst");

        // R3: long burst, only the last 14 bits count
        en_n = 1'b0; wait_cyc(4);
        for (int k = 0; k < 6; k++) send_bit(1'b1);
        begin
            logic [13:0] f = {12'h3C5, 2'b11};
            for (int k = 13; k >= 0; k--) send_bit(f[k]);
        end
        release_high();
        check_model("R3 long burst");
        check("R3 long burst main", 32'(main_r), 32'h3C5);

        // R2: short burst of two bits shifts the held word
        en_n = 1'b0; wait_cyc(4);
        send_bit(1'b0); send_bit(1'b1);
        release_high();
        check_model("R2 short burst");
        check("R2 R6 short burst ref", 32'(ref_r), 32'h17);

        // R5: 13 clocked bits, last bit taken by release with clock low
        en_n = 1'b0; wait_cyc(4);
        begin
            logic [13:0] f = {12'h6B4, 2'b11};
            for (int k = 13; k >= 1; k--) send_bit(f[k]);
            release_low(f[0]);
        end
        check_model("R5 release low");
        check("R5 main", 32'(main_r), 32'h6B4);

        // R10: reset again mid-run
        rst_n = 1'b0; wait_cyc(3);
        check("R10 re-reset ref", 32'(ref_r), 32'd1);
        check("R10 re-reset main", 32'(main_r), 32'd128);
        rst_n = 1'b1; wait_cyc(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule